// File: doc/BRIEF.md
# Streaming 5x5 Neighbourhood Window Filter

This block takes a raster-ordered stream of 32-bit unsigned pixels through a valid/ready input. It returns one result pixel for each input pixel through a valid/ready output. The frame width and height arrive on two size inputs. They are captured when a start pulse is accepted, so they need only hold during that pulse. The block walks a scan position over the real image plus two extra flush columns at the end of every row and two extra flush rows at the end of the frame. During the flush positions no input is read. This lets the results of the last rows and columns drain out.

Recent rows live in per-row line stores, one bank per stored row. Every bank is read and written at the current column in the same cycle. A 5x5 register window shifts left each time a pixel is taken. The result for a window position is the 32-bit wrapped sum of the 25 window pixels. A result whose centre pixel lies within two pixels of any edge is forced to zero. Output k belongs to input pixel k, because the results trail the input by a fixed two rows and two columns.

A three-state controller sequences the frame. The states are `ST_IDLE` after reset, `ST_SCAN` while iterating, and `ST_DONE` after the last iteration. The transitions are:
- launch: from `ST_IDLE` or `ST_DONE` to `ST_SCAN` on start.
- finish: from `ST_SCAN` to `ST_DONE` when the step at row height+1 and column width+1 completes.

Any stall on either side freezes the whole scan.

Top module: `nbf_window_filter`

## Requirements
- R1: After reset, and whenever `busy` is low, `in_ready` and `out_valid` are low, whatever `in_valid` does. Both `busy` and `done` are low after reset.
- R2: A `start` pulse seen while not busy captures `frame_cols` and `frame_rows`. It sets `busy` high and `done` low from the next cycle. A `start` pulse while busy is ignored, and the frame in progress keeps its captured size.
- R3: A pixel is taken only at scan positions with row < height and column < width. Exactly width×height pixels are taken per frame. With no stalls a frame occupies exactly (height+2)×(width+2) busy cycles, which leaves two idle input cycles at the end of every row.
- R4: Exactly width×height results are emitted per frame, in raster order. Result k belongs to the input pixel at row k/width, column k mod width.
- R5: For a centre pixel at row y, column x with 2 ≤ y < height−2 and 2 ≤ x < width−2, the result is the sum of the 25 input pixels in rows y−2..y+2 and columns x−2..x+2.
- R6: Every other result is zero, including every result of a frame smaller than 5 in either dimension.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the scan holds. No result is lost or repeated under any pattern of backpressure.
- R8: At a read position with `in_valid` low, `out_valid` is low and the scan holds. No result is lost or repeated under any pattern of input gaps.
- R9: Sums are taken modulo 2^32.
- R10: `done` rises in the cycle after the final result handshake. It stays high with `busy` low until the next accepted `start`.
- R11: Frames run back to back with different sizes, with no reset between them, produce correct results. Nothing from an earlier frame reaches a later frame's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a frame; captures the size inputs |
| frame_cols | input | 5 | Frame width in pixels, 0 to MAX_COLS |
| frame_rows | input | 5 | Frame height in pixels |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel taken this cycle when valid |
| in_data | input | 32 | Input pixel |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 32 | Result pixel (window sum or zero) |
| busy | output | 1 | Controller in `ST_SCAN` |
| done | output | 1 | Controller in `ST_DONE` |

## Verification
A corrupted line store or window register appears on `out_data` as a wrong interior sum. This happens no later than the next result whose window covers the damaged pixel, which is at most two rows after the pixel entered. A wrong scan counter shows up at the ports in two ways. It changes the number of pixels taken or results emitted per frame. It also moves the cycle in which `done` rises against the final result handshake. A stall-coupling fault shows up in the same cycle as a handshake taken on one side while the other side is stalled. It is visible one result later as a lost or repeated result.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

endpackage

// File: rtl/nbf_line_bank.sv
// One row of pixel history: a column-addressed store with an
// asynchronous read and a synchronous write at the same address.
module nbf_line_bank #(
    parameter int PIX_W = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [PIX_W-1:0] wr_data,
    output logic [PIX_W-1:0] rd_data
);

    logic [PIX_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wr_data;
        end
    end

    assign rd_data = cells[addr];

endmodule

// File: rtl/nbf_window.sv
// WIN x WIN register window. "preview" presents the shifted window
// combinationally; "commit" stores it.
module nbf_window #(
    parameter int PIX_W = 32,
    parameter int WIN   = 5,
    localparam int ROW_BITS = WIN * PIX_W,
    localparam int ALL_BITS = WIN * WIN * PIX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                preview,
    input  logic                commit,
    input  logic [ROW_BITS-1:0] col_in,
    output logic [ALL_BITS-1:0] view
);

    logic [PIX_W-1:0] cell_q [WIN][WIN];

    for (genvar r = 0; r < WIN; r++) begin : g_row
        for (genvar j = 0; j < WIN; j++) begin : g_col
            logic [PIX_W-1:0] shifted;

            if (j == WIN - 1) begin : g_edge
                assign shifted = col_in[r*PIX_W +: PIX_W];
            end else begin : g_inner
                assign shifted = cell_q[r][j+1];
            end

            assign view[(r*WIN + j)*PIX_W +: PIX_W] = preview ? shifted : cell_q[r][j];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q[r][j] <= '0;
                end else if (commit) begin
                    cell_q[r][j] <= shifted;
                end
            end
        end
    end

endmodule

// File: rtl/nbf_sum.sv
// Wrapping sum of N packed pixels.
module nbf_sum #(
    parameter int PIX_W = 32,
    parameter int N     = 25
) (
    input  logic [N*PIX_W-1:0] terms,
    output logic [PIX_W-1:0]   total
);

    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + terms[i*PIX_W +: PIX_W];
        end
    end

endmodule

// File: rtl/nbf_scan_ctrl.sv
// Frame sequencer: scan counters, read/emit position decode, and the
// joint stall rule for both stream sides.
module nbf_scan_ctrl
    import nbf_pkg::*;
#(
    parameter int WIN = 5,
    parameter int CW  = 5,
    parameter int RW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] frame_cols,
    input  logic [RW-1:0] frame_rows,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          rd_pos,
    output logic          take,
    output logic          inner,
    output logic [CW-1:0] col_idx,
    output logic          busy,
    output logic          done
);

    localparam int HALF = WIN / 2;
    localparam logic [CW-1:0] C_HALF  = CW'(HALF);
    localparam logic [RW-1:0] R_HALF  = RW'(HALF);
    localparam logic [CW-1:0] C_EDGE  = CW'(WIN - 1);
    localparam logic [RW-1:0] R_EDGE  = RW'(WIN - 1);
    localparam logic [CW-1:0] C_FLUSH = CW'(HALF - 1);
    localparam logic [RW-1:0] R_FLUSH = RW'(HALF - 1);

    scan_state_e   state_q, state_d;
    logic [CW-1:0] cols_q, col_q;
    logic [RW-1:0] rows_q, row_q;

    logic scanning, em_pos, in_go, out_go, adv, launch;
    logic col_end, row_end;

    assign scanning = (state_q == ST_SCAN);
    assign launch   = start && (state_q != ST_SCAN);
    assign col_end  = (col_q == cols_q + C_FLUSH);
    assign row_end  = (row_q == rows_q + R_FLUSH);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)                      state_d = ST_SCAN;
            ST_SCAN: if (adv && col_end && row_end)   state_d = ST_DONE;
            ST_DONE: if (launch)                      state_d = ST_SCAN;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // State register, captured size and scan position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cols_q  <= '0;
            rows_q  <= '0;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                cols_q <= frame_cols;
                rows_q <= frame_rows;
                col_q  <= '0;
                row_q  <= '0;
            end else if (adv) begin
                if (col_end) begin
                    col_q <= '0;
                    row_q <= row_q + RW'(1);
                end else begin
                    col_q <= col_q + CW'(1);
                end
            end
        end
    end

    // Outputs and position decode
    always_comb begin
        rd_pos    = scanning && (row_q < rows_q) && (col_q < cols_q);
        em_pos    = scanning && (row_q >= R_HALF) && (col_q >= C_HALF);
        in_go     = !rd_pos || in_valid;
        out_go    = !em_pos || out_ready;
        adv       = scanning && in_go && out_go;
        in_ready  = rd_pos && out_go;
        out_valid = em_pos && in_go;
        take      = rd_pos && adv;
        inner     = (row_q >= R_EDGE) && (row_q < rows_q) &&
                    (col_q >= C_EDGE) && (col_q < cols_q);
        col_idx   = col_q;
        busy      = scanning;
        done      = (state_q == ST_DONE);
    end

endmodule

// File: rtl/nbf_window_filter.sv
module nbf_window_filter #(
    parameter int PIX_W    = 32,
    parameter int WIN      = 5,
    parameter int MAX_COLS = 16,
    parameter int MAX_ROWS = 16,
    localparam int CW      = $clog2(MAX_COLS + WIN),
    localparam int RW      = $clog2(MAX_ROWS + WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    frame_cols,
    input  logic [RW-1:0]    frame_rows,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             busy,
    output logic             done
);

    localparam int AW     = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;
    localparam int STORES = WIN - 1;

    logic          rd_pos, take, inner;
    logic [CW-1:0] col_idx;
    logic [AW-1:0] bank_addr;

    logic [PIX_W-1:0]           store_rd [STORES];
    logic [WIN*PIX_W-1:0]       fresh_col;
    logic [WIN*WIN*PIX_W-1:0]   win_view;
    logic [PIX_W-1:0]           win_sum;

    nbf_scan_ctrl #(
        .WIN (WIN),
        .CW  (CW),
        .RW  (RW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_cols (frame_cols),
        .frame_rows (frame_rows),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .rd_pos     (rd_pos),
        .take       (take),
        .inner      (inner),
        .col_idx    (col_idx),
        .busy       (busy),
        .done       (done)
    );

    assign bank_addr = col_idx[AW-1:0];

    // The newest row is the live pixel itself; only WIN-1 older rows are stored.
    assign fresh_col[STORES*PIX_W +: PIX_W] = in_data;

    for (genvar b = 0; b < STORES; b++) begin : g_store
        logic [PIX_W-1:0] wr_val;

        if (b == STORES - 1) begin : g_top
            assign wr_val = in_data;
        end else begin : g_mid
            assign wr_val = store_rd[b+1];
        end

        assign fresh_col[b*PIX_W +: PIX_W] = store_rd[b];

        nbf_line_bank #(
            .PIX_W (PIX_W),
            .DEPTH (MAX_COLS)
        ) u_bank (
            .clk     (clk),
            .wr_en   (take),
            .addr    (bank_addr),
            .wr_data (wr_val),
            .rd_data (store_rd[b])
        );
    end

    nbf_window #(
        .PIX_W (PIX_W),
        .WIN   (WIN)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .preview (rd_pos),
        .commit  (take),
        .col_in  (fresh_col),
        .view    (win_view)
    );

    nbf_sum #(
        .PIX_W (PIX_W),
        .N     (WIN * WIN)
    ) u_sum (
        .terms (win_view),
        .total (win_sum)
    );

    assign out_data = inner ? win_sum : '0;

endmodule

// File: rtl/nbf_window_filter_chk.sv
module nbf_window_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic busy,
    input logic done
);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !out_valid));

    a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    a_r7_backpressure_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_starved_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |-> !out_valid);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind nbf_window_filter nbf_window_filter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/nbf_window_filter_test.sv
`timescale 1ns/1ps
module nbf_window_filter_test;

    localparam int PIX_W = 32;
    localparam int WIN   = 5;
    localparam int MAXC  = 16;
    localparam int MAXR  = 16;
    localparam int CW    = $clog2(MAXC + WIN);
    localparam int RW    = $clog2(MAXR + WIN);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CW-1:0]    frame_cols = '0;
    logic [RW-1:0]    frame_rows = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PIX_W-1:0] in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PIX_W-1:0] out_data;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] img [0:MAXC*MAXR-1];

    always #2 clk = ~clk;

    nbf_window_filter #(
        .PIX_W    (PIX_W),
        .WIN      (WIN),
        .MAX_COLS (MAXC),
        .MAX_ROWS (MAXR)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_cols (frame_cols),
        .frame_rows (frame_rows),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .busy       (busy),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_pix(input int k, input int w, input int h);
        int y, x;
        logic [31:0] acc;
        y = k / w;
        x = k % w;
        acc = '0;
        if (y >= 2 && y < h - 2 && x >= 2 && x < w - 2) begin
            for (int dy = -2; dy <= 2; dy++)
                for (int dx = -2; dx <= 2; dx++)
                    acc = acc + img[(y + dy) * w + (x + dx)];
        end
        return acc;
    endfunction

    function automatic bit interior(input int k, input int w, input int h);
        int y, x;
        y = k / w;
        x = k % w;
        return (y >= 2 && y < h - 2 && x >= 2 && x < w - 2);
    endfunction

    // kind 0: small ramp values, kind 1: large values that overflow
    task automatic run_frame(input int w, input int h, input int kind, input int seed,
                             input bit bp, input bit starve, input bit poke);
        int in_idx, out_idx, cyc, busy_cyc, done_cyc, last_fire;
        logic [31:0] exp;
        string tag;
        for (int i = 0; i < w * h; i++)
            img[i] = (kind == 0) ? 32'(i * 3 + seed) : (32'hF000_0000 + 32'(i) * 32'h0123_4567 + 32'(seed));

        @(negedge clk);
        frame_cols = CW'(w);
        frame_rows = RW'(h);
        start = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
        check(done == 1'b0, "R2", "done cleared by start", 32'(done), 0);

        in_idx = 0; out_idx = 0; cyc = 0; busy_cyc = 0; done_cyc = -1; last_fire = -1;
        while (done_cyc < 0 && cyc < 20000) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_valid  = (in_idx < w * h) && (!starve || lfsr[0] || lfsr[5]);
            in_data   = in_valid ? img[in_idx] : '0;
            out_ready = !bp || lfsr[3] || lfsr[8];
            if (poke && cyc == 6) begin
                start = 1'b1; frame_cols = CW'(3); frame_rows = RW'(2);
            end else if (poke && cyc == 7) begin
                start = 1'b0; frame_cols = CW'(w); frame_rows = RW'(h);
            end
            #1;
            if (done) begin
                done_cyc = cyc;
                check(busy == 1'b0, "R10", "busy low with done", 32'(busy), 0);
            end
            if (busy) busy_cyc++;
            if (in_valid && in_ready) in_idx++;
            if (out_valid && out_ready) begin
                if (out_idx >= w * h) begin
                    check(1'b0, "R4", "extra result", 32'(out_idx), 32'(w * h));
                end else begin
                    exp = ref_pix(out_idx, w, h);
                    tag = interior(out_idx, w, h) ? (kind == 1 ? "R9" : "R5") : "R6";
                    check(out_data == exp, tag, $sformatf("result %0d", out_idx), out_data, exp);
                end
                out_idx++;
                last_fire = cyc;
            end
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        check(done_cyc >= 0, "R10", "done reached", 32'(done_cyc), 0);
        check(out_idx == w * h, "R4", "result count", 32'(out_idx), 32'(w * h));
        check(in_idx == w * h, "R3", "pixels taken", 32'(in_idx), 32'(w * h));
        check(done_cyc == last_fire + 1, "R10", "done one cycle after last result",
              32'(done_cyc), 32'(last_fire + 1));
        if (!bp && !starve)
            check(busy_cyc == (h + 2) * (w + 2), "R3", "busy cycles unstalled",
                  32'(busy_cyc), 32'((h + 2) * (w + 2)));
        in_valid = 1'b1;
        #1;
        check(!in_ready && !out_valid, "R1", "quiet after frame", {30'd0, in_ready, out_valid}, 0);
        check(done == 1'b1, "R10", "done holds", 32'(done), 1);
        in_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!in_ready, "R1", "in_ready after reset", 32'(in_ready), 0);
        check(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 0);
        check(!busy && !done, "R1", "busy/done after reset", {30'd0, busy, done}, 0);
        in_valid = 1'b0;
    endtask

    task automatic t_plain();        run_frame(8, 7, 0, 11, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_backpressure(); run_frame(9, 8, 0, 5, 1'b1, 1'b0, 1'b0);  endtask
    task automatic t_starve();       run_frame(7, 9, 0, 99, 1'b0, 1'b1, 1'b0); endtask
    task automatic t_wrap();         run_frame(6, 6, 1, 3, 1'b1, 1'b1, 1'b0);  endtask
    task automatic t_tiny();
        run_frame(1, 1, 0, 7, 1'b0, 1'b0, 1'b0);
        run_frame(4, 3, 0, 2, 1'b0, 1'b0, 1'b0);
    endtask
    task automatic t_start_ignored(); run_frame(8, 6, 0, 40, 1'b0, 1'b0, 1'b1); endtask
    task automatic t_back_to_back();  // R11: full width, then a narrower frame
        run_frame(16, 5, 0, 1000, 1'b0, 1'b0, 1'b0);
        run_frame(5, 10, 1, 77, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_plain();
        t_backpressure();
        t_starve();
        t_wrap();
        t_tiny();
        t_start_ignored();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule